// File: doc/BRIEF.md
# In-Order Completion Queue

This block keeps a record of each instruction from the moment dispatch hands it to an execution unit until it retires. The record is a small circular first-in/first-out ring. Dispatch can claim up to two slots per cycle. Each claimed slot hands back an entry tag. Execution units later report "finished" against that tag, together with a flag that marks an exception or a mispredicted branch.

Retirement always happens in program order from the head, at most two instructions per cycle. Each retiring instruction raises a commit strobe, which stands in for the write to the architected registers. An unfinished head holds back everything behind it. An entry flagged with a fault retires alone and empties the whole ring, so recovery always starts from a precise state. The free-slot count is exported so that dispatch can stall when no slot is left.

Top module: `in_order_cq`

## Requirements
- R1: The ring has DEPTH (default 6) slots. `free_cnt_o` equals DEPTH minus the number of occupied slots. After reset it reads DEPTH, and `commit_o`, `flush_o` and `alloc_gnt_o` are all zero.
- R2: Slot request 0 is granted when `alloc_vld_i[0]` is high and at least one slot is free. Slot request 1 is granted only when both request bits are high and at least two slots are free. Granted requests receive tags `tail` and `tail+1`, taken modulo DEPTH.
- R3: A request that exceeds the free count is not granted and changes no state. The bench checks this through the grant bits and the free count.
- R4: At most two entries retire per cycle. `commit_o[0]` and `commit_o[1]` mark the oldest and second-oldest entries, with their tags on `commit_tag0_o` and `commit_tag1_o`. The strobes are combinational in the cycle in which the head is finished.
- R5: An unfinished head blocks retirement of every younger entry, even entries that have already finished.
- R6: The second-oldest entry retires only in a cycle in which the head also retires without a fault, and only if it is itself finished without a fault.
- R7: When allocation and retirement happen in the same cycle, the occupancy becomes old − retired + granted. This also holds when the ring is full, where grants use the free count from the start of that cycle.
- R8: A head that is finished with the fault flag set retires alone (`commit_o` = 01) and raises `flush_o` in that cycle. No allocation is granted in that cycle. From the next cycle on, the ring is empty and the next tags start at 0.
- R9: A finish report whose tag names an unoccupied slot is ignored. That slot does not count as finished when it is later allocated.
- R10: A finish report is registered at the clock edge. The entry can retire from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alloc_vld_i | input | 2 | Slot requests from dispatch, bit 0 oldest |
| alloc_gnt_o | output | 2 | Granted slot requests |
| alloc_tag0_o | output | TAG_W | Tag for request 0 |
| alloc_tag1_o | output | TAG_W | Tag for request 1 |
| free_cnt_o | output | CNT_W | Number of free slots |
| fin_vld_i | input | 2 | Finish reports from two execution ports |
| fin_tag0_i | input | TAG_W | Tag of finish report 0 |
| fin_tag1_i | input | TAG_W | Tag of finish report 1 |
| fin_exc_i | input | 2 | Fault flag of each finish report |
| commit_o | output | 2 | Retire strobes, bit 0 is the head |
| commit_tag0_o | output | TAG_W | Tag retired on strobe 0 |
| commit_tag1_o | output | TAG_W | Tag retired on strobe 1 |
| flush_o | output | 1 | Ring flush caused by a faulting head |

## Verification
The bench first fills the ring one slot at a time and compares the free count with its arithmetic value at every step. It then presses double requests against a full ring, which separates grant-by-free-count from grant-by-request. Finish reports arrive young-before-old and also against freed tags, to show that blocking at the head and the rejection of stale reports both hold. Faults are placed first at the head and then in the second-oldest slot, which tells a flush-alone retirement apart from a pair retirement, and a second run of allocations after the wrap shows that the pointers were reset.

// File: rtl/cq_pkg.sv
package cq_pkg;

    // Advance a ring index by a small step (step < depth).
    function automatic int unsigned cq_wrap(int unsigned idx, int unsigned step,
                                            int unsigned depth);
        int unsigned sum;
        sum = idx + step;
        return (sum >= depth) ? (sum - depth) : sum;
    endfunction

    typedef enum logic [1:0] {
        RET_NONE = 2'b00,
        RET_ONE  = 2'b01,
        RET_TWO  = 2'b11
    } ret_mode_e;

endpackage

// File: rtl/cq_alloc_ctl.sv
module cq_alloc_ctl #(
    parameter int unsigned DEPTH = 6,
    parameter int unsigned TAG_W = $clog2(DEPTH),
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [1:0]       req_i,
    input  logic [CNT_W-1:0] free_i,
    input  logic             flush_i,
    input  logic [TAG_W-1:0] tail_i,
    output logic [1:0]       gnt_o,
    output logic [TAG_W-1:0] tag0_o,
    output logic [TAG_W-1:0] tag1_o
);
    import cq_pkg::*;

    always_comb begin
        gnt_o[0] = req_i[0] && (free_i >= CNT_W'(1)) && !flush_i;
        gnt_o[1] = req_i[0] && req_i[1] && (free_i >= CNT_W'(2)) && !flush_i;
        tag0_o   = tail_i;
        tag1_o   = TAG_W'(cq_wrap(32'(tail_i), 1, DEPTH));
    end
endmodule

// File: rtl/cq_retire_sel.sv
module cq_retire_sel (
    input  logic       head_vld_i,
    input  logic       head_done_i,
    input  logic       head_exc_i,
    input  logic       next_vld_i,
    input  logic       next_done_i,
    input  logic       next_exc_i,
    output logic [1:0] commit_o,
    output logic       flush_o
);
    import cq_pkg::*;

    ret_mode_e mode;

    always_comb begin
        mode = RET_NONE;
        if (head_vld_i && head_done_i) begin
            mode = RET_ONE;
            if (!head_exc_i && next_vld_i && next_done_i && !next_exc_i) begin
                mode = RET_TWO;
            end
        end
        commit_o = mode;
        flush_o  = head_vld_i && head_done_i && head_exc_i;
    end
endmodule

// File: rtl/in_order_cq.sv
module in_order_cq #(
    parameter int unsigned DEPTH = 6,
    parameter int unsigned TAG_W = $clog2(DEPTH),
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       alloc_vld_i,
    output logic [1:0]       alloc_gnt_o,
    output logic [TAG_W-1:0] alloc_tag0_o,
    output logic [TAG_W-1:0] alloc_tag1_o,
    output logic [CNT_W-1:0] free_cnt_o,
    input  logic [1:0]       fin_vld_i,
    input  logic [TAG_W-1:0] fin_tag0_i,
    input  logic [TAG_W-1:0] fin_tag1_i,
    input  logic [1:0]       fin_exc_i,
    output logic [1:0]       commit_o,
    output logic [TAG_W-1:0] commit_tag0_o,
    output logic [TAG_W-1:0] commit_tag1_o,
    output logic             flush_o
);
    import cq_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0] occ;
        logic [DEPTH-1:0] done;
        logic [DEPTH-1:0] exc;
        logic [TAG_W-1:0] head;
        logic [TAG_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
    } cq_state_t;

    cq_state_t st_d, st_q;

    logic [TAG_W-1:0] head_nx;
    logic             h_occ, h_done, h_exc;
    logic             n_occ, n_done, n_exc;
    logic [TAG_W-1:0] fin_tag [2];

    assign head_nx    = TAG_W'(cq_wrap(32'(st_q.head), 1, DEPTH));
    assign free_cnt_o = CNT_W'(DEPTH) - st_q.cnt;
    assign fin_tag[0] = fin_tag0_i;
    assign fin_tag[1] = fin_tag1_i;

    // Pick out the two oldest entries.
    always_comb begin
        h_occ = 1'b0; h_done = 1'b0; h_exc = 1'b0;
        n_occ = 1'b0; n_done = 1'b0; n_exc = 1'b0;
        for (int e = 0; e < DEPTH; e++) begin
            if (st_q.head == TAG_W'(e)) begin
                h_occ = st_q.occ[e]; h_done = st_q.done[e]; h_exc = st_q.exc[e];
            end
            if (head_nx == TAG_W'(e)) begin
                n_occ = st_q.occ[e]; n_done = st_q.done[e]; n_exc = st_q.exc[e];
            end
        end
    end

    cq_retire_sel i_ret (
        .head_vld_i  (h_occ),
        .head_done_i (h_done),
        .head_exc_i  (h_exc),
        .next_vld_i  (n_occ),
        .next_done_i (n_done),
        .next_exc_i  (n_exc),
        .commit_o    (commit_o),
        .flush_o     (flush_o)
    );

    cq_alloc_ctl #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) i_alloc (
        .req_i   (alloc_vld_i),
        .free_i  (free_cnt_o),
        .flush_i (flush_o),
        .tail_i  (st_q.tail),
        .gnt_o   (alloc_gnt_o),
        .tag0_o  (alloc_tag0_o),
        .tag1_o  (alloc_tag1_o)
    );

    assign commit_tag0_o = st_q.head;
    assign commit_tag1_o = head_nx;

    always_comb begin
        logic [1:0] n_ret, n_all;
        st_d  = st_q;
        n_ret = {1'b0, commit_o[0]} + {1'b0, commit_o[1]};
        n_all = {1'b0, alloc_gnt_o[0]} + {1'b0, alloc_gnt_o[1]};

        // Finish reports land only on occupied slots.
        for (int u = 0; u < 2; u++) begin
            for (int e = 0; e < DEPTH; e++) begin
                if (fin_vld_i[u] && fin_tag[u] == TAG_W'(e) && st_q.occ[e]) begin
                    st_d.done[e] = 1'b1;
                    st_d.exc[e]  = fin_exc_i[u];
                end
            end
        end

        if (flush_o) begin
            st_d.occ  = '0;
            st_d.done = '0;
            st_d.exc  = '0;
            st_d.head = '0;
            st_d.tail = '0;
            st_d.cnt  = '0;
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if ((commit_o[0] && st_q.head == TAG_W'(e)) ||
                    (commit_o[1] && head_nx == TAG_W'(e))) begin
                    st_d.occ[e]  = 1'b0;
                    st_d.done[e] = 1'b0;
                    st_d.exc[e]  = 1'b0;
                end
                if ((alloc_gnt_o[0] && alloc_tag0_o == TAG_W'(e)) ||
                    (alloc_gnt_o[1] && alloc_tag1_o == TAG_W'(e))) begin
                    st_d.occ[e]  = 1'b1;
                    st_d.done[e] = 1'b0;
                    st_d.exc[e]  = 1'b0;
                end
            end
            st_d.head = TAG_W'(cq_wrap(32'(st_q.head), 32'(n_ret), DEPTH));
            st_d.tail = TAG_W'(cq_wrap(32'(st_q.tail), 32'(n_all), DEPTH));
            st_d.cnt  = st_q.cnt - CNT_W'(n_ret) + CNT_W'(n_all);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
    parameter int unsigned DEPTH = 6,
    parameter int unsigned TAG_W = $clog2(DEPTH),
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [1:0]       alloc_gnt_o,
    input logic [CNT_W-1:0] free_cnt_o,
    input logic [1:0]       commit_o,
    input logic [TAG_W-1:0] commit_tag0_o,
    input logic [TAG_W-1:0] commit_tag1_o,
    input logic             flush_o
);
    logic armed_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    // R1
    free_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        free_cnt_o <= CNT_W'(DEPTH));

    // R2
    pair_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alloc_gnt_o[1] |-> alloc_gnt_o[0]);

    // R3
    full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (free_cnt_o == '0) |-> (alloc_gnt_o == 2'b00));

    // R6
    order_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_o[1] |-> (commit_o[0] && !flush_o));

    // R4
    tag_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_o[1] |-> (commit_tag1_o != commit_tag0_o));

    // R8
    flush_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |-> (commit_o == 2'b01 && alloc_gnt_o == 2'b00));

    // R8
    flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |=> (free_cnt_o == CNT_W'(DEPTH)));

    // R7
    occ_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && !$past(flush_o)) |->
        (int'(free_cnt_o) == int'($past(free_cnt_o)) + $countones($past(commit_o))
                             - $countones($past(alloc_gnt_o))));
endmodule

bind in_order_cq cq_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) i_cq_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .alloc_gnt_o   (alloc_gnt_o),
    .free_cnt_o    (free_cnt_o),
    .commit_o      (commit_o),
    .commit_tag0_o (commit_tag0_o),
    .commit_tag1_o (commit_tag1_o),
    .flush_o       (flush_o)
);

// File: tb/test_in_order_cq.sv
`timescale 1ns/1ps
module test_in_order_cq;
    localparam int DEPTH = 6;
    localparam int TAG_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic [1:0]       alloc_vld_i = '0;
    logic [1:0]       alloc_gnt_o;
    logic [TAG_W-1:0] alloc_tag0_o, alloc_tag1_o;
    logic [CNT_W-1:0] free_cnt_o;
    logic [1:0]       fin_vld_i = '0;
    logic [TAG_W-1:0] fin_tag0_i = '0, fin_tag1_i = '0;
    logic [1:0]       fin_exc_i = '0;
    logic [1:0]       commit_o;
    logic [TAG_W-1:0] commit_tag0_o, commit_tag1_o;
    logic             flush_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #5 clk_i = ~clk_i;

    in_order_cq #(.DEPTH(DEPTH)) i_in_order_cq (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, settle, leave checks to the caller.
    task automatic cyc(input logic [1:0] av, input logic [1:0] fv,
                       input int ft0, input int ft1, input logic [1:0] fe);
        @(negedge clk_i);
        alloc_vld_i = av;
        fin_vld_i   = fv;
        fin_tag0_i  = TAG_W'(ft0);
        fin_tag1_i  = TAG_W'(ft1);
        fin_exc_i   = fe;
        #1;
    endtask

    initial begin
        #20000000;
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;

        cyc(2'b00, 2'b00, 0, 0, 2'b00);
        chk("R1 reset free", free_cnt_o, DEPTH);
        chk("R1 reset commit", commit_o, 0);
        chk("R1 reset flush", flush_o, 0);
        chk("R1 reset grant", alloc_gnt_o, 0);

        // Fill one slot per cycle; free count steps down arithmetically.
        for (int k = 1; k <= DEPTH; k++) begin
            cyc(2'b01, 2'b00, 0, 0, 2'b00);
            chk("R2 single grant", alloc_gnt_o, 1);
            chk("R2 single tag", alloc_tag0_o, k - 1);
            chk("R1 free while filling", free_cnt_o, DEPTH - k + 1);
        end
        cyc(2'b11, 2'b00, 0, 0, 2'b00);
        chk("R1 full free", free_cnt_o, 0);
        chk("R3 full stall grant", alloc_gnt_o, 0);
        cyc(2'b00, 2'b01, 1, 0, 2'b00);              // tag1 finishes first
        chk("R3 free unchanged", free_cnt_o, 0);
        cyc(2'b00, 2'b00, 0, 0, 2'b00);
        chk("R5 blocked by head", commit_o, 0);
        cyc(2'b11, 2'b01, 0, 0, 2'b00);              // head finishes now
        chk("R10 not before edge", commit_o, 0);
        chk("R3 full grant", alloc_gnt_o, 0);
        cyc(2'b11, 2'b00, 0, 0, 2'b00);
        chk("R4 pair commit", commit_o, 3);
        chk("R4 tag0", commit_tag0_o, 0);
        chk("R4 tag1", commit_tag1_o, 1);
        chk("R7 full with retire grant", alloc_gnt_o, 0);
        cyc(2'b11, 2'b11, 2, 3, 2'b00);
        chk("R7 free after retire", free_cnt_o, 2);
        chk("R2 pair grant", alloc_gnt_o, 3);
        chk("R2 wrapped tag0", alloc_tag0_o, 0);
        chk("R2 wrapped tag1", alloc_tag1_o, 1);
        cyc(2'b00, 2'b11, 4, 5, 2'b00);
        chk("R4 commit 2,3", commit_o, 3);
        chk("R4 commit tag 2", commit_tag0_o, 2);
        chk("R7 refill free", free_cnt_o, 0);
        cyc(2'b00, 2'b00, 0, 0, 2'b00);
        chk("R4 commit 4,5", commit_o, 3);
        chk("R4 commit tag 4", commit_tag0_o, 4);
        cyc(2'b00, 2'b10, 0, 3, 2'b00);              // tag3 is free: stale report
        chk("R5 head 0 not done", commit_o, 0);
        chk("R7 free", free_cnt_o, 4);
        cyc(2'b11, 2'b00, 0, 0, 2'b00);
        chk("R2 tags after wrap", alloc_tag0_o, 2);
        cyc(2'b00, 2'b11, 0, 1, 2'b00);
        cyc(2'b00, 2'b00, 0, 0, 2'b00);
        chk("R4 commit 0,1", commit_o, 3);
        cyc(2'b00, 2'b00, 0, 0, 2'b00);
        chk("R9 stale report ignored", commit_o, 0);
        chk("R9 free", free_cnt_o, 4);

        // Fault at the head.
        cyc(2'b00, 2'b11, 2, 3, 2'b01);
        cyc(2'b11, 2'b00, 0, 0, 2'b00);
        chk("R8 alone", commit_o, 1);
        chk("R8 tag", commit_tag0_o, 2);
        chk("R8 flush", flush_o, 1);
        chk("R8 no grant", alloc_gnt_o, 0);
        cyc(2'b11, 2'b00, 0, 0, 2'b00);
        chk("R8 empty", free_cnt_o, DEPTH);
        chk("R8 flush drops", flush_o, 0);
        chk("R8 tag restart", alloc_tag0_o, 0);
        chk("R8 tag restart 1", alloc_tag1_o, 1);

        // Fault in the second-oldest slot.
        cyc(2'b00, 2'b11, 0, 1, 2'b10);
        cyc(2'b00, 2'b00, 0, 0, 2'b00);
        chk("R6 head only", commit_o, 1);
        chk("R6 no flush", flush_o, 0);
        cyc(2'b00, 2'b00, 0, 0, 2'b00);
        chk("R8 second fault alone", commit_o, 1);
        chk("R8 second fault tag", commit_tag0_o, 1);
        chk("R8 second fault flush", flush_o, 1);
        cyc(2'b00, 2'b00, 0, 0, 2'b00);
        chk("R8 empty again", free_cnt_o, DEPTH);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule